// File: doc/BRIEF.md
# Write-Invalidate Snooping Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared snooping bus. It holds a tag and a three-state coherence tag for every line of a small direct-mapped array. A line is Invalid when it holds no data. It is Shared when it is clean and readable and other caches may also hold it. It is Exclusive when this cache holds the only copy, which is writable and dirty. Processor requests that hit with enough permission finish in the cycle they are presented. Any other request raises a bus request and waits. The bus transaction it needs, together with the resulting state change, takes effect in the single cycle in which the grant is seen.

The controller also watches every transaction that other caches put on the bus. If it holds the addressed line, it reports a hit. When its copy is the dirty owner, it signals a flush, which supplies the data and writes it back. It then downgrades or drops the line as the protocol requires. Data storage, memory and arbitration between caches live outside the block. The grant input stands in for the arbiter. The rule is that a grant to this cache and a snooped transaction never occur in the same cycle.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address needs a bus transaction. Reset in the middle of operation discards an Exclusive line in the same way.
- R2: A read to a line held Shared or Exclusive with a matching tag raises cpu_done in the same cycle and leaves bus_req low.
- R3: A read miss raises bus_req with bus_op = 1 (read miss) and bus_addr = cpu_addr. In the granted cycle cpu_done is high and the line becomes Shared.
- R4: A write miss raises bus_req with bus_op = 2 (write miss). In the granted cycle cpu_done is high and the line becomes Exclusive. A later write to that Exclusive line completes at once with no bus request.
- R5: A write to a Shared line with a matching tag raises bus_req with bus_op = 3 (invalidate) and bus_addr = cpu_addr. In the granted cycle cpu_done is high and the line becomes Exclusive.
- R6: A miss whose index holds a different tag in Exclusive first issues bus_op = 4 (write-back) with bus_addr = {victim tag, index}, leaves cpu_done low and invalidates the line. The miss itself follows on a later grant. A Shared victim is dropped silently, and the miss is issued at once.
- R7: While bus_req is high and bus_gnt is low, cpu_done stays low and no state changes. bus_gnt and snoop_valid are never high in the same cycle. The address is split as tag = upper bits and index = lower IDX_W bits.
- R8: A snooped read miss (snoop_op = 1) to a held line raises snoop_hit. If the line is Exclusive, snoop_flush is also high and the line becomes Shared. A Shared line stays Shared with snoop_flush low.
- R9: A snooped write miss (2) or invalidate (3) to a held line raises snoop_hit and makes the line Invalid. snoop_flush is high only if the line was Exclusive.
- R10: A snooped transaction with a different tag, with op 0 or 4, or with snoop_valid low gives snoop_hit = 0 and snoop_flush = 0, and changes no state.
- R11: If a snooped invalidate removes a Shared line while a write to it waits for the grant, the pending request becomes a write miss (bus_op = 2). This serialises the two writers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor block address |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_op | output | 3 | Own transaction: 0 none, 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | Address of own transaction, 0 when idle |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_op | input | 3 | Snooped transaction code, same encoding as bus_op |
| snoop_addr | input | ADDR_W | Snooped block address |
| snoop_hit | output | 1 | This cache holds the snooped line |
| snoop_flush | output | 1 | This cache owns the dirty copy and supplies or writes it back |

## Verification
The bench goes after the cases where two actions meet on one index. The first is the eviction of a dirty victim: a design that skipped the write-back would lose the only copy, and one that reported done early would complete a miss never placed on the bus. The second is a snooped invalidate arriving while an upgrade waits for grant: a design that kept the stale op would issue an invalidate for data it no longer holds and break write ordering. Snoops with mismatching tags, write-back ops or no valid are used to catch a controller that drops or flushes lines it should leave alone. Each state change is then proven indirectly, through the bus op the next request produces.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_RDMISS = 3'd1,
    OP_WRMISS = 3'd2,
    OP_INVAL  = 3'd3,
    OP_WRBACK = 3'd4
  } bus_op_e;

  // Bus transaction a processor request needs, given the line it maps to.
  function automatic bus_op_e cpu_bus_op(line_st_e st, logic tag_eq, logic we);
    if (st == ST_EXC && !tag_eq) return OP_WRBACK;      // dirty victim first
    if (st == ST_INV || !tag_eq) return we ? OP_WRMISS : OP_RDMISS;
    if (we && st == ST_SHR)      return OP_INVAL;       // upgrade
    return OP_NONE;                                      // plain hit
  endfunction

  // Line state after this cache's own granted transaction.
  function automatic line_st_e cpu_next_st(line_st_e st, bus_op_e op);
    case (op)
      OP_RDMISS:           return ST_SHR;
      OP_WRMISS, OP_INVAL: return ST_EXC;
      OP_WRBACK:           return ST_INV;
      default:             return st;
    endcase
  endfunction

  // True when a snooped op concerns a held line at all.
  function automatic logic snoop_relevant(bus_op_e op);
    return (op == OP_RDMISS) || (op == OP_WRMISS) || (op == OP_INVAL);
  endfunction

  // Line state after a snooped transaction that hit.
  function automatic line_st_e snoop_next_st(line_st_e st, bus_op_e op);
    if (op == OP_RDMISS) return (st == ST_EXC) ? ST_SHR : st;
    if (op == OP_WRMISS || op == OP_INVAL) return ST_INV;
    return st;
  endfunction

endpackage

// File: rtl/coh_tag_store.sv
module coh_tag_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic [TAG_W-1:0] cpu_tag_o,
  output line_st_e         cpu_st_o,
  input  logic [IDX_W-1:0] snp_idx,
  output logic [TAG_W-1:0] snp_tag_o,
  output line_st_e         snp_st_o,
  input  logic             cpu_wr,
  input  line_st_e         cpu_wst,
  input  logic [TAG_W-1:0] cpu_wtag,
  input  logic             snp_wr,
  input  line_st_e         snp_wst
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_e         st_q  [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_INV;
        tag_q[i] <= '0;
      end
    end else if (cpu_wr) begin
      st_q[cpu_idx]  <= cpu_wst;
      tag_q[cpu_idx] <= cpu_wtag;
    end else if (snp_wr) begin
      st_q[snp_idx] <= snp_wst;
    end
  end

  assign cpu_tag_o = tag_q[cpu_idx];
  assign cpu_st_o  = st_q[cpu_idx];
  assign snp_tag_o = tag_q[snp_idx];
  assign snp_st_o  = st_q[snp_idx];

  // R7: the own-request and snoop update paths never write together
  a_r7_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && snp_wr));

endmodule

// File: rtl/coh_req_ctrl.sv
module coh_req_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  line_st_e          line_st,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  logic              bus_gnt,
  output logic              cpu_done,
  output logic              bus_req,
  output bus_op_e           bus_op_o,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              upd_en,
  output line_st_e          upd_st,
  output logic [ADDR_W-IDX_W-1:0] upd_tag
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic             tag_eq;
  bus_op_e          need_op;

  assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign req_idx = cpu_addr[IDX_W-1:0];
  assign tag_eq  = (line_tag == req_tag);
  assign need_op = cpu_bus_op(line_st, tag_eq, cpu_we);

  assign bus_req  = cpu_req && (need_op != OP_NONE);
  assign bus_op_o = bus_req ? need_op : OP_NONE;
  assign cpu_done = cpu_req &&
                    ((need_op == OP_NONE) || (bus_gnt && need_op != OP_WRBACK));

  always_comb begin
    bus_addr = '0;
    if (bus_req) bus_addr = (need_op == OP_WRBACK) ? {line_tag, req_idx} : cpu_addr;
  end

  assign upd_en  = bus_req && bus_gnt;
  assign upd_st  = cpu_next_st(line_st, need_op);
  assign upd_tag = req_tag;

  // R6: a granted victim write-back is never repeated for the same request
  a_r6_wb_followed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_op_o == OP_WRBACK)
    |=> !(bus_req && bus_op_o == OP_WRBACK && cpu_addr == $past(cpu_addr)));

  // R5: after a granted upgrade the same address needs no second invalidate
  a_r5_upgrade_once: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_op_o == OP_INVAL)
    |=> !(bus_req && bus_op_o == OP_INVAL && cpu_addr == $past(cpu_addr)));

  // R4: a granted write miss leaves the line writable without the bus
  a_r4_exc_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_op_o == OP_WRMISS)
    |=> !(cpu_req && cpu_we && cpu_addr == $past(cpu_addr) && bus_req));

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              snoop_valid,
  input  bus_op_e           snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  line_st_e          line_st,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  output logic              snoop_hit,
  output logic              snoop_flush,
  output logic              upd_en,
  output line_st_e          upd_st
);
  logic tag_eq;

  assign tag_eq      = (line_tag == snoop_addr[ADDR_W-1:IDX_W]);
  assign snoop_hit   = snoop_valid && snoop_relevant(snoop_op) &&
                       (line_st != ST_INV) && tag_eq;
  assign snoop_flush = snoop_hit && (line_st == ST_EXC);
  assign upd_en      = snoop_hit;
  assign upd_st      = snoop_next_st(line_st, snoop_op);

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              snoop_valid,
  input  logic [2:0]        snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_hit,
  output logic              snoop_flush
);
  localparam int TAG_W = ADDR_W - IDX_W;

  // named internal events
  logic [TAG_W-1:0] cpu_line_tag, snp_line_tag, req_upd_tag;
  line_st_e         cpu_line_st, snp_line_st, req_upd_st, snp_upd_st;
  logic             req_upd_en, snp_upd_en;
  bus_op_e          own_op;
  bus_op_e          snp_op_e;

  assign snp_op_e = bus_op_e'(snoop_op);
  assign bus_op   = own_op;

  coh_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_idx   (cpu_addr[IDX_W-1:0]),
    .cpu_tag_o (cpu_line_tag),
    .cpu_st_o  (cpu_line_st),
    .snp_idx   (snoop_addr[IDX_W-1:0]),
    .snp_tag_o (snp_line_tag),
    .snp_st_o  (snp_line_st),
    .cpu_wr    (req_upd_en),
    .cpu_wst   (req_upd_st),
    .cpu_wtag  (req_upd_tag),
    .snp_wr    (snp_upd_en),
    .snp_wst   (snp_upd_st)
  );

  coh_req_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .line_st  (cpu_line_st),
    .line_tag (cpu_line_tag),
    .bus_gnt  (bus_gnt),
    .cpu_done (cpu_done),
    .bus_req  (bus_req),
    .bus_op_o (own_op),
    .bus_addr (bus_addr),
    .upd_en   (req_upd_en),
    .upd_st   (req_upd_st),
    .upd_tag  (req_upd_tag)
  );

  coh_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snp (
    .snoop_valid (snoop_valid),
    .snoop_op    (snp_op_e),
    .snoop_addr  (snoop_addr),
    .line_st     (snp_line_st),
    .line_tag    (snp_line_tag),
    .snoop_hit   (snoop_hit),
    .snoop_flush (snoop_flush),
    .upd_en      (snp_upd_en),
    .upd_st      (snp_upd_st)
  );

  // R7: usage rule, one bus master per cycle
  a_r7_gnt_snoop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_gnt && snoop_valid));

  // R7: an ungranted bus request never completes
  a_r7_stall_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && bus_req && !bus_gnt) |-> !cpu_done);

  // R8: after supplying dirty data the line is no longer owned
  a_r8_flush_once: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_flush |=> !(snoop_flush && snoop_addr == $past(snoop_addr)));

  // R9: a snooped write miss or invalidate removes the copy
  a_r9_drop_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && (snp_op_e == OP_WRMISS || snp_op_e == OP_INVAL))
    |=> !(snoop_hit && snoop_addr == $past(snoop_addr)));

endmodule

// File: tb/snoop_coh_ctrl_tb.sv
module snoop_coh_ctrl_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, bus_gnt, snoop_valid;
  logic [15:0] cpu_addr, snoop_addr, bus_addr;
  logic [2:0]  snoop_op, bus_op;
  logic        cpu_done, bus_req, snoop_hit, snoop_flush;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  snoop_coh_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_done(cpu_done), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_op(bus_op), .bus_addr(bus_addr),
    .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_addr(snoop_addr),
    .snoop_hit(snoop_hit), .snoop_flush(snoop_flush)
  );

  typedef struct packed {
    logic        rq; logic we; logic [15:0] a; logic g;
    logic        sv; logic [2:0] so; logic [15:0] sa;
    logic        ed; logic er; logic [2:0] eo; logic [15:0] ea;
    logic        eh; logic ef; logic [7:0] r;
  } vec_t;

  // A=0x0010 (idx0 tag2), B=0x0018 (idx0 tag3), C=0x0021 (idx1 tag4)
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1,0,16'h0010,0, 0,0,16'h0, 0,1,1,16'h0010, 0,0, 8'd3},  // R1 R7 stall on read miss
    '{1,0,16'h0010,1, 0,0,16'h0, 1,1,1,16'h0010, 0,0, 8'd3},  // R3 granted
    '{1,0,16'h0010,0, 0,0,16'h0, 1,0,0,16'h0,    0,0, 8'd2},  // R2 read hit
    '{1,1,16'h0010,0, 0,0,16'h0, 0,1,3,16'h0010, 0,0, 8'd5},  // R5 upgrade waits
    '{1,1,16'h0010,1, 0,0,16'h0, 1,1,3,16'h0010, 0,0, 8'd5},  // R5 granted
    '{1,1,16'h0010,0, 0,0,16'h0, 1,0,0,16'h0,    0,0, 8'd4},  // R4 silent write
    '{1,0,16'h0018,1, 0,0,16'h0, 0,1,4,16'h0010, 0,0, 8'd6},  // R6 victim write-back
    '{1,0,16'h0018,1, 0,0,16'h0, 1,1,1,16'h0018, 0,0, 8'd3},  // R3 then miss
    '{1,0,16'h0010,0, 0,0,16'h0, 0,1,1,16'h0010, 0,0, 8'd6},  // R6 shared victim
    '{0,0,16'h0,0,    1,1,16'h0018, 0,0,0,16'h0, 1,0, 8'd8},  // R8 shared read snoop
    '{1,0,16'h0018,0, 0,0,16'h0, 1,0,0,16'h0,    0,0, 8'd8},  // R8 still shared
    '{0,0,16'h0,0,    1,3,16'h0018, 0,0,0,16'h0, 1,0, 8'd9},  // R9 invalidate shared
    '{1,0,16'h0018,0, 0,0,16'h0, 0,1,1,16'h0018, 0,0, 8'd9},  // R9 now invalid
    '{1,1,16'h0021,1, 0,0,16'h0, 1,1,2,16'h0021, 0,0, 8'd4},  // R4 write miss
    '{0,0,16'h0,0,    1,2,16'h0029, 0,0,0,16'h0, 0,0, 8'd10}, // R10 tag mismatch
    '{0,0,16'h0,0,    1,4,16'h0021, 0,0,0,16'h0, 0,0, 8'd10}, // R10 write-back op
    '{0,0,16'h0,0,    1,1,16'h0021, 0,0,0,16'h0, 1,1, 8'd8},  // R8 flush owned
    '{1,1,16'h0021,0, 0,0,16'h0, 0,1,3,16'h0021, 0,0, 8'd8},  // R8 now shared
    '{1,1,16'h0021,0, 1,3,16'h0021, 0,1,3,16'h0021, 1,0, 8'd11}, // R11 lost race
    '{1,1,16'h0021,1, 0,0,16'h0, 1,1,2,16'h0021, 0,0, 8'd11}, // R11 becomes write miss
    '{0,0,16'h0,0,    1,2,16'h0021, 0,0,0,16'h0, 1,1, 8'd9},  // R9 flush then drop
    '{1,0,16'h0021,0, 0,0,16'h0, 0,1,1,16'h0021, 0,0, 8'd9}   // R9 now invalid
  };

  task automatic chk(input int r, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic drive(input logic rq, input logic we, input logic [15:0] a,
                       input logic g, input logic sv, input logic [2:0] so,
                       input logic [15:0] sa);
    @(negedge clk);
    cpu_req = rq; cpu_we = we; cpu_addr = a; bus_gnt = g;
    snoop_valid = sv; snoop_op = so; snoop_addr = sa;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; bus_gnt = 0;
    snoop_valid = 0; snoop_op = '0; snoop_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 idle outputs after reset
    chk(1, "cpu_done idle", cpu_done, 0);
    chk(1, "bus_req idle", bus_req, 0);
    chk(1, "bus_op idle", bus_op, 0);
    chk(1, "snoop_hit idle", snoop_hit, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].rq, VEC[i].we, VEC[i].a, VEC[i].g, VEC[i].sv, VEC[i].so, VEC[i].sa);
      chk(VEC[i].r, $sformatf("row %0d cpu_done", i), cpu_done, VEC[i].ed);
      chk(VEC[i].r, $sformatf("row %0d bus_req", i), bus_req, VEC[i].er);
      chk(VEC[i].r, $sformatf("row %0d bus_op", i), bus_op, VEC[i].eo);
      if (VEC[i].er)
        chk(VEC[i].r, $sformatf("row %0d bus_addr", i), bus_addr, VEC[i].ea);
      chk(VEC[i].r, $sformatf("row %0d snoop_hit", i), snoop_hit, VEC[i].eh);
      chk(VEC[i].r, $sformatf("row %0d snoop_flush", i), snoop_flush, VEC[i].ef);
    end

    // R10: matching read snoop without valid is ignored (C made Shared first)
    drive(1, 0, 16'h0021, 1, 0, 3'd0, 16'h0);
    chk(3, "C read miss done", cpu_done, 1);
    drive(0, 0, 16'h0, 0, 0, 3'd3, 16'h0021);
    chk(10, "snoop_hit without valid", snoop_hit, 0);
    drive(1, 0, 16'h0021, 0, 0, 3'd0, 16'h0);
    chk(10, "C still readable", cpu_done, 1);
    chk(10, "C no bus", bus_req, 0);

    // R1: reset in operation drops an Exclusive line
    drive(1, 1, 16'h0010, 1, 0, 3'd0, 16'h0);
    chk(4, "A write miss op", bus_op, 2);
    drive(1, 1, 16'h0010, 0, 0, 3'd0, 16'h0);
    chk(4, "A exclusive write silent", bus_req, 0);
    @(negedge clk) begin rst_n = 1'b0; cpu_req = 0; end
    @(negedge clk) rst_n = 1'b1;
    drive(1, 1, 16'h0010, 0, 0, 3'd0, 16'h0);
    chk(1, "write after reset needs bus", bus_req, 1);
    chk(1, "write after reset op", bus_op, 2);
    chk(7, "no done while ungranted", cpu_done, 0);
    drive(0, 0, 16'h0, 0, 0, 3'd0, 16'h0);

    finish_run();
  end

endmodule